// File: doc/BRIEF.md
# Backlight Dimming Pulse-Width Generator

This block produces one pulse-width modulated output of the kind that dims a display backlight. An 8-bit period counter advances on a divided tick. The source of that tick is chosen between a slow low-frequency strobe and the system clock, and the selected source is then divided by a power of two. The output is in its active phase while the counter is below an 8-bit compare value. A polarity control decides whether the active phase drives the pin high or low. Every period is 256 divided ticks long, so the duty cycle runs from 0/256 to 255/256 and can never reach a full period.

Software uses a small synchronous register port. One write-one register starts the generator and a second write-one register stops it. A status register reports whether the generator is really running, and software polls it after either request. A new compare value or prescaler code written while running waits for the next counter wrap, so no period is cut short. A start takes effect on the next divided tick. A stop takes effect at the end of the current period. Both clock sources are modelled as clock-enable strobes inside one clock domain.

Top module: `bl_pwm`

## Requirements
- R1: After reset the generator is stopped and status bit 0 reads 0. The configuration register and the general register read 0. The output is high, which is the inactive level for polarity 0.
- R2: While running, one period is 256 divided ticks. With normal polarity the output is high for compare x 2^p source ticks of each period, where p is the prescaler code.
- R3: Prescaler code 7 acts exactly like code 6, giving a divide by 64. The active prescaler never holds 7.
- R4: Compare 0 gives an output that is never active. Compare 255 gives 255 active ticks out of 256. The output is inactive whenever the counter is at 255.
- R5: Configuration bit 4 set gives normal polarity, high during the active phase. Bit 4 clear inverts the output.
- R6: Writing 1 to bit 0 of the start register (address 2) starts the generator on the next divided tick. At that point status bit 0 becomes 1.
- R7: Writing 1 to bit 0 of the stop register (address 3) stops the generator only at the counter wrap that ends the current period. Status then reads 0 and the output goes to its inactive level.
- R8: Writing 0 to bit 0 of the start or stop register has no effect on the running state or on the output.
- R9: The compare value (configuration bits 15:8) and the prescaler code (bits 2:0) written while running change the active settings only at a counter wrap.
- R10: General register (address 0) bit 0 selects the tick source. Clear selects the slow strobe input and set selects the system clock.
- R11: While stopped, the counter is held at zero and the output stays at the inactive level for the current polarity.
- R12: A read returns, one cycle later, the configuration register (address 1) as written, the general register, or the running state in bit 0 of the status register (address 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| slow_tick | input | 1 | One-cycle strobe marking each edge of the slow source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read strobe |
| pwm_out | output | 1 | Dimming output |

## Verification
Several rules are checked by assertions on every cycle. The active compare value and prescaler code only move at a wrap or while stopped. Starting lines up with a divided tick, and stopping lines up with a wrap. The active prescaler never holds code 7. A stopped generator shows its inactive level, and the output is never active at count 255. The duty cycle itself can only be shown by the bench's scenarios: high-time counts for each prescaler code and compare value, inverted polarity, and the slow source. The same holds for the delay between a start or stop request and the status bit, and for the fact that zero writes are ignored.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int AW       = 3;
  localparam int DW       = 16;
  localparam int CW       = 8;
  localparam int PW       = 3;
  localparam int PS_LIMIT = 6;

  localparam logic [AW-1:0] ADR_GEN   = 3'd0;
  localparam logic [AW-1:0] ADR_CFG   = 3'd1;
  localparam logic [AW-1:0] ADR_START = 3'd2;
  localparam logic [AW-1:0] ADR_STOP  = 3'd3;
  localparam logic [AW-1:0] ADR_STAT  = 3'd4;

  localparam int CMP_LSB  = 8;
  localparam int POL_BIT  = 4;
  localparam int PS_LSB   = 0;
  localparam int SRC_BIT  = 0;
  localparam int RUN_BIT  = 0;
  localparam int REQ_BIT  = 0;

  typedef struct packed {
    logic [CW-1:0] cmp;
    logic          pol;
    logic [PW-1:0] ps;
    logic          src_sys;
  } cfg_t;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          running,
  output cfg_t          cfg,
  output logic          start_pulse,
  output logic          stop_pulse,
  output logic [DW-1:0] bus_rdata
);
  cfg_t          cfg_q, cfg_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic [DW-1:0] rd_mux;

  always_comb begin
    cfg_d = cfg_q;
    if (bus_wr && bus_addr == ADR_CFG) begin
      cfg_d.cmp = bus_wdata[CMP_LSB +: CW];
      cfg_d.pol = bus_wdata[POL_BIT];
      cfg_d.ps  = bus_wdata[PS_LSB +: PW];
    end
    if (bus_wr && bus_addr == ADR_GEN) begin
      cfg_d.src_sys = bus_wdata[SRC_BIT];
    end
  end

  always_comb begin
    start_pulse = bus_wr && (bus_addr == ADR_START) && bus_wdata[REQ_BIT];
    stop_pulse  = bus_wr && (bus_addr == ADR_STOP)  && bus_wdata[REQ_BIT];
  end

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      ADR_CFG: begin
        rd_mux[CMP_LSB +: CW] = cfg_q.cmp;
        rd_mux[POL_BIT]       = cfg_q.pol;
        rd_mux[PS_LSB +: PW]  = cfg_q.ps;
      end
      ADR_GEN:  rd_mux[SRC_BIT] = cfg_q.src_sys;
      ADR_STAT: rd_mux[RUN_BIT] = running;
      default:  rd_mux = '0;
    endcase
    rdata_d = bus_rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      rdata_q <= '0;
    end else begin
      cfg_q   <= cfg_d;
      rdata_q <= rdata_d;
    end
  end

  assign cfg       = cfg_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/bl_pwm_prescaler.sv
module bl_pwm_prescaler
  import bl_pwm_pkg::*;
#(
  parameter int DIVW = PS_LIMIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          src_sys,
  input  logic [PW-1:0] ps,
  output logic          tick
);
  logic [DIVW-1:0] div_q, div_d;
  logic [DIVW-1:0] mask;
  logic            src_tick;

  always_comb begin
    src_tick = src_sys ? 1'b1 : slow_tick;
    mask     = DIVW'((32'd1 << ps) - 32'd1);
    div_d    = src_tick ? div_q + 1'b1 : div_q;
    tick     = src_tick && ((div_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
  import bl_pwm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start_pulse,
  input  logic          stop_pulse,
  input  logic [CW-1:0] cmp_in,
  input  logic [PW-1:0] ps_in,
  input  logic          pol,
  output logic          run,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cmp_act,
  output logic [PW-1:0] ps_act,
  output logic          wrap,
  output logic          pwm_out
);
  localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};
  localparam logic [PW-1:0] PS_SAT  = PW'(PS_LIMIT);

  logic          run_q, run_d;
  logic          start_req_q, start_req_d;
  logic          stop_req_q, stop_req_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cmp_q, cmp_d;
  logic [PW-1:0] ps_q, ps_d;
  logic [PW-1:0] ps_clamped;
  logic          begin_run, load, active;

  always_comb begin
    ps_clamped = (ps_in > PS_SAT) ? PS_SAT : ps_in;
    wrap       = run_q && tick && (cnt_q == CNT_TOP);
    begin_run  = !run_q && tick && start_req_q;
    load       = !run_q || wrap;

    run_d = run_q;
    if (begin_run)              run_d = 1'b1;
    else if (wrap && stop_req_q) run_d = 1'b0;

    start_req_d = start_req_q;
    stop_req_d  = stop_req_q;
    if (start_pulse) begin
      start_req_d = 1'b1;
      stop_req_d  = 1'b0;
    end
    if (stop_pulse) begin
      stop_req_d  = 1'b1;
      start_req_d = 1'b0;
    end
    if (run_d)  start_req_d = 1'b0;
    if (!run_d) stop_req_d  = 1'b0;

    cnt_d = cnt_q;
    if (begin_run)          cnt_d = '0;
    else if (run_q && tick) cnt_d = cnt_q + 1'b1;
    if (!run_d)             cnt_d = '0;

    cmp_d = load ? cmp_in     : cmp_q;
    ps_d  = load ? ps_clamped : ps_q;

    active  = run_q && (cnt_q < cmp_q);
    pwm_out = pol ? active : !active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      start_req_q <= 1'b0;
      stop_req_q  <= 1'b0;
      cnt_q       <= '0;
      cmp_q       <= '0;
      ps_q        <= '0;
    end else begin
      run_q       <= run_d;
      start_req_q <= start_req_d;
      stop_req_q  <= stop_req_d;
      cnt_q       <= cnt_d;
      cmp_q       <= cmp_d;
      ps_q        <= ps_d;
    end
  end

  assign run     = run_q;
  assign cnt     = cnt_q;
  assign cmp_act = cmp_q;
  assign ps_act  = ps_q;
endmodule

// File: rtl/bl_pwm.sv
module bl_pwm
  import bl_pwm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          pwm_out
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  cfg_t          cfg;
  logic          start_pulse, stop_pulse;
  logic          tick_w, run_w, wrap_w;
  logic [CW-1:0] cnt_w, cmp_act_w;
  logic [PW-1:0] ps_act_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bl_pwm_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .running     (run_w),
    .cfg         (cfg),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse),
    .bus_rdata   (bus_rdata)
  );

  bl_pwm_prescaler u_presc (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .slow_tick (slow_tick),
    .src_sys   (cfg.src_sys),
    .ps        (ps_act_w),
    .tick      (tick_w)
  );

  bl_pwm_core u_core (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .tick        (tick_w),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse),
    .cmp_in      (cfg.cmp),
    .ps_in       (cfg.ps),
    .pol         (cfg.pol),
    .run         (run_w),
    .cnt         (cnt_w),
    .cmp_act     (cmp_act_w),
    .ps_act      (ps_act_w),
    .wrap        (wrap_w),
    .pwm_out     (pwm_out)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk
  import bl_pwm_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cmp_act,
  input logic [PW-1:0] ps_act,
  input logic          tick,
  input logic          wrap,
  input logic          pol,
  input logic          pwm_out
);
  // R9
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(wrap)) |-> ($stable(cmp_act) && $stable(ps_act)));

  // R6
  start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(tick));

  // R7
  stop_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $past(wrap));

  // R3
  ps_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ps_act != 3'd7);

  // R11
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pwm_out == !pol && cnt == '0));

  // R4
  top_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == {CW{1'b1}}) |-> (pwm_out == !pol));
endmodule

bind bl_pwm bl_pwm_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .run     (run_w),
  .cnt     (cnt_w),
  .cmp_act (cmp_act_w),
  .ps_act  (ps_act_w),
  .tick    (tick_w),
  .wrap    (wrap_w),
  .pol     (cfg.pol),
  .pwm_out (pwm_out)
);

// File: tb/bl_pwm_tb.sv
module bl_pwm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 180000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        pwm_out;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int slow_div = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bl_pwm u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  // Slow source: one strobe every 4 system cycles
  always @(negedge clk) begin
    slow_div  = (slow_div + 1) % 4;
    slow_tick <= (slow_div == 0);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG_LIMIT) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WDOG_LIMIT);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [15:0] cfgw(input int cmp, input bit pol, input int ps);
    return 16'((cmp << 8) | (int'(pol) << 4) | ps);
  endfunction

  task automatic high_count(input int len, output int hi);
    hi = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  task automatic poll_status(input int exp, input int limit, output int ok);
    logic [15:0] d;
    ok = 0;
    for (int i = 0; i < limit; i++) begin
      rd(3'd4, d);
      if (int'(d[0]) == exp) begin
        ok = 1;
        break;
      end
    end
  endtask

  initial begin
    logic [15:0] d;
    int hi, ok, len, cmp_v;
    int cmps[4] = '{0, 1, 100, 255};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 output idle high", int'(pwm_out), 1);
    rd(3'd4, d); chk("R1 status", int'(d), 0);
    rd(3'd1, d); chk("R1 cfg", int'(d), 0);
    rd(3'd0, d); chk("R1 gen", int'(d), 0);

    // R10/R12 select system clock, read back
    wr(3'd0, 16'h0001);
    rd(3'd0, d); chk("R12 gen readback", int'(d), 1);
    wr(3'd1, cfgw(10, 1'b1, 0));
    rd(3'd1, d); chk("R12 cfg readback", int'(d), int'(cfgw(10, 1'b1, 0)));

    // R8 zero write to start register
    wr(3'd2, 16'h0000);
    repeat (20) @(negedge clk);
    rd(3'd4, d); chk("R8 start zero status", int'(d[0]), 0);
    chk("R11 idle low with pol=1", int'(pwm_out), 0);

    // R6 start
    wr(3'd2, 16'h0001);
    poll_status(1, 4, ok); chk("R6 status rises", ok, 1);

    // R2/R4 sweep of prescaler code and compare value
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 4; k++) begin
        cmp_v = cmps[k];
        len = 256 << p;
        wr(3'd1, cfgw(cmp_v, 1'b1, p));
        repeat (len) @(negedge clk);
        high_count(len, hi);
        chk($sformatf("R2 R4 p=%0d cmp=%0d", p, cmp_v), hi, cmp_v << p);
      end
    end

    // R3 code 7 behaves as 6
    wr(3'd1, cfgw(64, 1'b1, 7));
    rd(3'd1, d); chk("R12 cfg code7 readback", int'(d), int'(cfgw(64, 1'b1, 7)));
    repeat (256 * 64) @(negedge clk);
    high_count(256 * 64, hi);
    chk("R3 code7 high time", hi, 64 * 64);

    // R5 inverted polarity
    wr(3'd1, cfgw(100, 1'b0, 0));
    repeat (256) @(negedge clk);
    high_count(256, hi);
    chk("R5 inverted high time", hi, 156);

    // R10 slow source, one strobe per 4 cycles
    wr(3'd0, 16'h0000);
    wr(3'd1, cfgw(64, 1'b1, 0));
    repeat (1024) @(negedge clk);
    high_count(1024, hi);
    chk("R10 slow source high time", hi, 256);

    // R8 zero write to stop register
    wr(3'd0, 16'h0001);
    wr(3'd1, cfgw(100, 1'b1, 0));
    wr(3'd3, 16'h0000);
    repeat (300) @(negedge clk);
    rd(3'd4, d); chk("R8 stop zero status", int'(d[0]), 1);

    // R7 stop at period end
    wr(3'd3, 16'h0001);
    poll_status(0, 140, ok); chk("R7 status falls", ok, 1);
    high_count(300, hi);
    chk("R7 R11 idle after stop", hi, 0);

    // R11 inactive level follows polarity while stopped
    wr(3'd1, cfgw(100, 1'b0, 0));
    high_count(50, hi);
    chk("R11 idle high with pol=0", hi, 50);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule